// File: doc/BRIEF.md
# Constant-Mask Convolution Kernel with Selectable Multiplier Count

This block produces one output activation from a square K x K window of signed fixed-point activations. The mask coefficients are elaboration-time constants, so synthesis can fold zero, one and power-of-two coefficients into wiring or shifts. A mode parameter sets how many multipliers exist, which trades latency against area. With one multiplier, the products are formed one per cycle. With K multipliers, one per mask column, the window is processed one row per cycle. With K*K multipliers, every product is formed in the same cycle, and each multiplier is tied to a single fixed coefficient with no multiplexer in front of it.

A producer presents the whole window in parallel and uses a valid/ready handshake. The dot product has no bias term. It is shifted right arithmetically by a fraction width, passed through an optional rectifier, and clipped to the activation width. The result appears on the output together with a one-cycle valid strobe. Line buffering, window extraction, stride, padding and summation across channels belong to the surrounding logic.

Top module: `conv_kernel`

## Requirements
- R1: The mask is K x K with K at least 3. Window and mask elements are two's-complement values stored row-major: element index i = row*K + col occupies bits [i*ACT_W +: ACT_W] of `in_win` and bits [i*W_W +: W_W] of the mask parameter.
- R2: The result equals the exact sum over all i of window[i]*mask[i], with no bias and no intermediate overflow. It is shifted right arithmetically by FRAC_W bits and then clipped to the signed ACT_W range.
- R3: In one-multiplier mode (PAR_SERIAL), a window accepted in cycle c produces `out_valid` in cycle c+K*K+1.
- R4: In column mode (PAR_COLUMN), K multipliers are used and a window accepted in cycle c produces `out_valid` in cycle c+K+1.
- R5: In fully parallel mode (PAR_FULL), `in_ready` is always high and a window accepted in cycle c produces its result in cycle c+1. Windows offered back to back each yield their own result.
- R6: In PAR_SERIAL and PAR_COLUMN, `in_ready` is low from the cycle after acceptance until the cycle in which `out_valid` is high. While `in_ready` is low, `in_win` and `in_valid` are ignored.
- R7: With RELU=1, a negative shifted result is output as 0. With RELU=0, negative values pass through, subject to clipping.
- R8: A shifted result above 2^(ACT_W-1)-1 is output as that maximum. A result below -2^(ACT_W-1) is output as that minimum.
- R9: After a synchronous reset, `out_valid` is 0, `out_data` is 0 and `in_ready` is 1.
- R10: `out_valid` is high for exactly one cycle per accepted window, and `out_data` holds its value between results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Window on `in_win` is offered |
| in_ready | output | 1 | Block can accept a window this cycle |
| in_win | input | K*K*ACT_W | Parallel window, row-major signed elements |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| out_data | output | ACT_W | Signed output activation |

## Verification
If the pass counter or the accumulator clear goes wrong, the result strobe arrives one or more cycles away from its fixed position, or the result carries a partial or doubled sum. Either fault is visible at the first window after reset. A wrong operand select in the shared-multiplier modes pairs an activation with a foreign coefficient, so windows with distinct element values produce a result that differs from the reference dot product. Faults in the post-processing stage show up only on windows that drive the sum negative or past the clip limits, which is why the vectors include all-maximum and all-minimum windows run through both the linear and the rectified configuration.

// File: rtl/conv_pkg.sv
package conv_pkg;

    typedef enum logic [1:0] {
        PAR_SERIAL = 2'd0,
        PAR_COLUMN = 2'd1,
        PAR_FULL   = 2'd2
    } conv_par_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } conv_state_e;

    function automatic int lanes_of(conv_par_e mode, int k);
        case (mode)
            PAR_SERIAL: return 1;
            PAR_COLUMN: return k;
            default:    return k * k;
        endcase
    endfunction

    function automatic int acc_width(int act_w, int w_w, int k);
        return act_w + w_w + $clog2(k * k);
    endfunction

endpackage

// File: rtl/conv_ctrl.sv
module conv_ctrl #(
    parameter int PASSES = 9,
    parameter int CNT_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    output logic             accept,
    output logic [CNT_W-1:0] pass_idx,
    output logic             first,
    output logic             last
);
    import conv_pkg::*;

    localparam logic [CNT_W-1:0] LAST_PASS = CNT_W'(PASSES - 1);

    conv_state_e      state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             running;

    assign running  = (state_q == ST_RUN);
    assign in_ready = (state_q == ST_IDLE);
    assign accept   = in_valid && in_ready;
    assign pass_idx = cnt_q;
    assign first    = running && (cnt_q == '0);
    assign last     = running && (cnt_q == LAST_PASS);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q <= ST_RUN;
                        cnt_q   <= '0;
                    end
                end
                default: begin
                    if (last) begin
                        state_q <= ST_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // R6: once a window is taken, the block stops accepting until it finishes
    a_r6_ready_drops: assert property (@(posedge clk) disable iff (rst)
        accept |=> !in_ready);

    // R6: the pass index never runs past the final pass
    a_r6_pass_bound: assert property (@(posedge clk) disable iff (rst)
        running |-> (pass_idx <= LAST_PASS));

    // R6: the run always ends by returning to idle after the last pass
    a_r6_ready_back: assert property (@(posedge clk) disable iff (rst)
        last |=> in_ready);

endmodule

// File: rtl/conv_opsel.sv
module conv_opsel #(
    parameter int                   K      = 3,
    parameter int                   ACT_W  = 8,
    parameter int                   W_W    = 8,
    parameter int                   LANES  = 3,
    parameter int                   CNT_W  = 2,
    parameter logic [K*K*W_W-1:0]   MASK   = '0
) (
    input  logic [K*K*ACT_W-1:0]   win,
    input  logic [CNT_W-1:0]       pass_idx,
    output logic [LANES*ACT_W-1:0] x_flat,
    output logic [LANES*W_W-1:0]   w_flat
);
    for (genvar l = 0; l < LANES; l++) begin : g_sel
        always_comb begin
            int idx;
            idx = int'(pass_idx) * LANES + l;
            x_flat[l*ACT_W +: ACT_W] = win[idx*ACT_W +: ACT_W];
            w_flat[l*W_W +: W_W]     = MASK[idx*W_W +: W_W];
        end
    end

endmodule

// File: rtl/conv_lane.sv
module conv_lane #(
    parameter int ACT_W = 8,
    parameter int W_W   = 8
) (
    input  logic [ACT_W-1:0]           x,
    input  logic [W_W-1:0]             w,
    output logic signed [ACT_W+W_W-1:0] prod
);
    localparam int PROD_W = ACT_W + W_W;

    logic signed [ACT_W-1:0] xs;
    logic signed [W_W-1:0]   ws;

    assign xs   = x;
    assign ws   = w;
    assign prod = PROD_W'(xs) * PROD_W'(ws);

endmodule

// File: rtl/conv_post.sv
module conv_post #(
    parameter int ACC_W  = 20,
    parameter int ACT_W  = 8,
    parameter int FRAC_W = 2,
    parameter bit RELU   = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    res_valid,
    input  logic signed [ACC_W-1:0] res_acc,
    output logic                    out_valid,
    output logic [ACT_W-1:0]        out_data
);
    localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((64'sd1 <<< (ACT_W - 1)) - 64'sd1);
    localparam logic signed [ACC_W-1:0] MINV = -MAXV - ACC_W'(1);

    logic signed [ACC_W-1:0] shifted;
    logic signed [ACC_W-1:0] rectified;
    logic [ACT_W-1:0]        clipped;

    always_comb begin
        shifted   = res_acc >>> FRAC_W;
        rectified = (RELU && shifted < 0) ? '0 : shifted;
        if (rectified > MAXV)
            clipped = MAXV[ACT_W-1:0];
        else if (rectified < MINV)
            clipped = MINV[ACT_W-1:0];
        else
            clipped = rectified[ACT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= res_valid;
            if (res_valid)
                out_data <= clipped;
        end
    end

    // R8: a sum beyond the positive range lands on the maximum code
    a_r8_clip_high: assert property (@(posedge clk) disable iff (rst)
        (res_valid && (res_acc >>> FRAC_W) > MAXV) |=> (out_data == MAXV[ACT_W-1:0]));

    // R8: a sum beyond the negative range lands on the minimum code (linear only)
    a_r8_clip_low: assert property (@(posedge clk) disable iff (rst)
        (!RELU && res_valid && (res_acc >>> FRAC_W) < MINV) |=> (out_data == MINV[ACT_W-1:0]));

    // R7: rectified configuration never emits a negative value for a negative sum
    a_r7_relu_zero: assert property (@(posedge clk) disable iff (rst)
        (RELU && res_valid && res_acc < 0) |=> (out_data == '0));

    // R10: the result register only changes with a new result
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !res_valid |=> $stable(out_data));

endmodule

// File: rtl/conv_kernel.sv
module conv_kernel #(
    parameter int                   K      = 3,
    parameter int                   ACT_W  = 8,
    parameter int                   W_W    = 8,
    parameter int                   FRAC_W = 2,
    parameter conv_pkg::conv_par_e  MODE   = conv_pkg::PAR_FULL,
    parameter bit                   RELU   = 1'b1,
    parameter logic [K*K*W_W-1:0]   MASK   = 72'h08FD01040002FF0100
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [K*K*ACT_W-1:0] in_win,
    output logic                 out_valid,
    output logic [ACT_W-1:0]     out_data
);
    import conv_pkg::*;

    localparam int NTAP   = K * K;
    localparam int LANES  = lanes_of(MODE, K);
    localparam int PASSES = NTAP / LANES;
    localparam int PROD_W = ACT_W + W_W;
    localparam int ACC_W  = acc_width(ACT_W, W_W, K);
    localparam int CNT_W  = (PASSES > 1) ? $clog2(PASSES) : 1;

    logic [LANES*ACT_W-1:0]     x_flat;
    logic [LANES*W_W-1:0]       w_flat;
    logic signed [PROD_W-1:0]   prod_a [LANES];
    logic signed [ACC_W-1:0]    lane_sum;
    logic                       res_valid;
    logic signed [ACC_W-1:0]    res_acc;
    logic                       accept;

    initial begin
        if (K < 3) $error("conv_kernel: K must be at least 3 (R1)");
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        conv_lane #(.ACT_W(ACT_W), .W_W(W_W)) u_lane (
            .x    (x_flat[l*ACT_W +: ACT_W]),
            .w    (w_flat[l*W_W +: W_W]),
            .prod (prod_a[l])
        );
    end

    always_comb begin
        lane_sum = '0;
        for (int l = 0; l < LANES; l++)
            lane_sum = lane_sum + ACC_W'(prod_a[l]);
    end

    if (PASSES == 1) begin : g_full
        // every multiplier is bound to one constant coefficient
        assign x_flat    = in_win;
        assign w_flat    = MASK;
        assign in_ready  = 1'b1;
        assign accept    = in_valid;
        assign res_valid = accept;
        assign res_acc   = lane_sum;

        // R5: a result follows every accepted window in the next cycle
        a_r5_next_cycle: assert property (@(posedge clk) disable iff (rst)
            accept |=> out_valid);

        // R10: no strobe without a window in the cycle before
        a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
            !accept |=> !out_valid);
    end else begin : g_shared
        logic [NTAP*ACT_W-1:0]   win_q;
        logic [CNT_W-1:0]        pass_idx;
        logic                    first;
        logic                    last;
        logic signed [ACC_W-1:0] acc_q;
        logic signed [ACC_W-1:0] acc_next;
        logic                    chk_busy;
        int                      chk_n;

        conv_ctrl #(.PASSES(PASSES), .CNT_W(CNT_W)) u_ctrl (
            .clk      (clk),
            .rst      (rst),
            .in_valid (in_valid),
            .in_ready (in_ready),
            .accept   (accept),
            .pass_idx (pass_idx),
            .first    (first),
            .last     (last)
        );

        conv_opsel #(
            .K(K), .ACT_W(ACT_W), .W_W(W_W), .LANES(LANES),
            .CNT_W(CNT_W), .MASK(MASK)
        ) u_opsel (
            .win      (win_q),
            .pass_idx (pass_idx),
            .x_flat   (x_flat),
            .w_flat   (w_flat)
        );

        always_ff @(posedge clk) begin
            if (rst)
                win_q <= '0;
            else if (accept)
                win_q <= in_win;
        end

        assign acc_next = (first ? '0 : acc_q) + lane_sum;

        always_ff @(posedge clk) begin
            if (rst)
                acc_q <= '0;
            else
                acc_q <= acc_next;
        end

        assign res_valid = last;
        assign res_acc   = acc_next;

        // latency observer: cycles since acceptance
        always_ff @(posedge clk) begin
            if (rst) begin
                chk_busy <= 1'b0;
                chk_n    <= 0;
            end else if (accept) begin
                chk_busy <= 1'b1;
                chk_n    <= 0;
            end else if (chk_busy) begin
                chk_n <= chk_n + 1;
                if (out_valid)
                    chk_busy <= 1'b0;
            end
        end

        // R3 and R4: the strobe arrives exactly PASSES edges after the accepting edge
        a_r4_latency: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> (chk_busy && chk_n == PASSES));

        // R3 and R4: the strobe is never skipped
        a_r4_no_drop: assert property (@(posedge clk) disable iff (rst)
            (chk_busy && chk_n == PASSES) |-> out_valid);
    end

    conv_post #(
        .ACC_W(ACC_W), .ACT_W(ACT_W), .FRAC_W(FRAC_W), .RELU(RELU)
    ) u_post (
        .clk       (clk),
        .rst       (rst),
        .res_valid (res_valid),
        .res_acc   (res_acc),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

endmodule

// File: tb/conv_kernel_test.sv
`timescale 1ns/1ps
module conv_kernel_test;
    import conv_pkg::*;

    localparam int K      = 3;
    localparam int NN     = K * K;
    localparam int ACT_W  = 8;
    localparam int W_W    = 8;
    localparam int FRAC_W = 2;
    localparam int WIN_W  = NN * ACT_W;
    // mask row-major: 0, 1, -1, 2, 0, 4, 1, -3, 8 (zero, one and power-of-two taps)
    localparam logic [NN*W_W-1:0] MASK = 72'h08FD01040002FF0100;

    localparam int NVEC = 6;
    localparam logic [WIN_W-1:0] VEC [NVEC] = '{
        72'h000000000000000000,
        72'h7F7F7F7F7F7F7F7F7F,
        72'h808080808080808080,
        72'h0102030405060708F9,
        72'h05F37F801122E009FE,
        72'hF0101F2E3D4C5B6A79
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [WIN_W-1:0] in_win = '0;
    logic v_par = 1'b0, v_col = 1'b0, v_ser = 1'b0;
    logic r_par, r_col, r_ser;
    logic o_par, o_col, o_ser;
    logic [ACT_W-1:0] d_par, d_col, d_ser;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    conv_kernel #(.K(K), .ACT_W(ACT_W), .W_W(W_W), .FRAC_W(FRAC_W),
                  .MODE(PAR_FULL), .RELU(1'b1), .MASK(MASK)) uut (
        .clk(clk), .rst(rst), .in_valid(v_par), .in_ready(r_par),
        .in_win(in_win), .out_valid(o_par), .out_data(d_par));

    conv_kernel #(.K(K), .ACT_W(ACT_W), .W_W(W_W), .FRAC_W(FRAC_W),
                  .MODE(PAR_COLUMN), .RELU(1'b1), .MASK(MASK)) u_col (
        .clk(clk), .rst(rst), .in_valid(v_col), .in_ready(r_col),
        .in_win(in_win), .out_valid(o_col), .out_data(d_col));

    conv_kernel #(.K(K), .ACT_W(ACT_W), .W_W(W_W), .FRAC_W(FRAC_W),
                  .MODE(PAR_SERIAL), .RELU(1'b0), .MASK(MASK)) u_ser (
        .clk(clk), .rst(rst), .in_valid(v_ser), .in_ready(r_ser),
        .in_win(in_win), .out_valid(o_ser), .out_data(d_ser));

    function automatic int ref_out(logic [WIN_W-1:0] w, bit relu);
        int s = 0;
        for (int i = 0; i < NN; i++)
            s += int'($signed(w[i*ACT_W +: ACT_W])) * int'($signed(MASK[i*W_W +: W_W]));
        s = s >>> FRAC_W;
        if (relu && s < 0) s = 0;
        if (s > 127) s = 127;
        if (s < -128) s = -128;
        return s;
    endfunction

    function automatic int sv(logic [ACT_W-1:0] d);
        return int'($signed(d));
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // offer one window to all three instances and follow each to its result
    task automatic run_all(logic [WIN_W-1:0] w);
        @(negedge clk);
        in_win = w;
        v_par = 1'b1; v_col = 1'b1; v_ser = 1'b1;
        @(posedge clk); #1;
        v_par = 1'b0; v_col = 1'b0; v_ser = 1'b0;
        for (int e = 0; e <= NN + 1; e++) begin
            if (e > 0) begin @(posedge clk); #1; end
            chk("R5 full strobe", int'(o_par), int'(e == 0));
            if (e == 0) chk("R2 full data", sv(d_par), ref_out(w, 1'b1));
            chk("R5 full ready", int'(r_par), 1);
            chk("R4 column strobe", int'(o_col), int'(e == K));
            if (e == K) chk("R4 column data", sv(d_col), ref_out(w, 1'b1));
            chk("R6 column ready", int'(r_col), int'(e >= K));
            chk("R3 serial strobe", int'(o_ser), int'(e == NN));
            if (e == NN) chk("R3 serial data", sv(d_ser), ref_out(w, 1'b0));
            chk("R6 serial ready", int'(r_ser), int'(e >= NN));
        end
    endtask

    initial begin
        // R9: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R9 full valid", int'(o_par), 0);
        chk("R9 full data", sv(d_par), 0);
        chk("R9 full ready", int'(r_par), 1);
        chk("R9 column ready", int'(r_col), 1);
        chk("R9 serial ready", int'(r_ser), 1);
        chk("R9 serial valid", int'(o_ser), 0);
        chk("R9 serial data", sv(d_ser), 0);

        // R1 R2: table of windows through all three schedules
        for (int j = 0; j < NVEC; j++)
            run_all(VEC[j]);

        // R7 R8: explicit clip and rectifier corner cases
        run_all(VEC[2]);
        chk("R7 rectified negative", sv(d_par), 0);
        chk("R8 clip low linear", sv(d_ser), -128);
        run_all(VEC[1]);
        chk("R8 clip high", sv(d_par), 127);
        chk("R8 clip high serial", sv(d_ser), 127);

        // R6: window changes and held valid during a run are ignored
        @(negedge clk);
        in_win = VEC[4];
        v_col = 1'b1; v_ser = 1'b1;
        @(posedge clk); #1;
        in_win = VEC[5];
        for (int e = 0; e <= NN; e++) begin
            if (e > 0) begin @(posedge clk); #1; end
            if (e == K) begin
                chk("R6 column ignores busy input", sv(d_col), ref_out(VEC[4], 1'b1));
                chk("R6 column strobe", int'(o_col), 1);
                v_col = 1'b0;
            end
            if (e == NN) begin
                chk("R6 serial ignores busy input", sv(d_ser), ref_out(VEC[4], 1'b0));
                chk("R6 serial strobe", int'(o_ser), 1);
                v_ser = 1'b0;
            end
        end
        @(posedge clk); #1;
        chk("R10 column no extra strobe", int'(o_col), 0);
        chk("R10 serial no extra strobe", int'(o_ser), 0);

        // R5: back-to-back windows in full mode
        for (int j = 3; j < 6; j++) begin
            @(negedge clk);
            in_win = VEC[j];
            v_par = 1'b1;
            @(posedge clk); #1;
            chk("R5 back-to-back strobe", int'(o_par), 1);
            chk("R5 back-to-back data", sv(d_par), ref_out(VEC[j], 1'b1));
        end
        v_par = 1'b0;
        @(posedge clk); #1;
        chk("R10 strobe ends", int'(o_par), 0);
        chk("R10 data holds", sv(d_par), ref_out(VEC[5], 1'b1));

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #500000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule